// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit general-purpose timer. The system clock feeds an optional fixed divide-by-16 stage and then a programmable 8-bit prescaler. Each prescaled tick advances a counter. When the counter matches a programmed reference value, the timer sets a sticky reference flag and the counter starts again from zero. A level interrupt is raised while that flag is set and the reference interrupt is enabled.

Software reaches the timer through a byte-addressed port with a write strobe, a read strobe and 16-bit data. It can program the mode and the reference, preset the count, read the live count, keep a value in the capture register, and clear event flags by writing ones to them. The block has no capture input, no output-pin toggling, no external clock source and no free-running mode.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, the mode, reference, capture, counter and event registers all read zero and `irq` is low.
- R2: While mode bit 0 (enable) is 0, the counter holds its value.
- R3: Mode bits [2:1] pick the tick source. Value 1 gives one tick every (P+1) clocks and value 2 gives one tick every 16*(P+1) clocks, where P is mode bits [15:8]. Each tick advances the counter by one.
- R4: Mode bits [2:1] equal to 0 or 3 give no ticks, so the counter does not advance.
- R5: On a tick that finds the counter equal to the reference, event bit 1 is set and the counter returns to zero. With a reference of zero, every tick sets the flag and the counter stays at zero.
- R6: `irq` is high exactly while mode bit 4 and event bit 1 are both set.
- R7: Writing the event register (offset 0x11) clears each bit written as 1 and leaves each bit written as 0. A flag set by hardware in the same cycle wins over the clear.
- R8: A mode write with bit 0 = 0, made while bit 0 is 1, clears the reference register and stores the written mode value. A mode write with bit 0 = 0 made while bit 0 is already 0 leaves the reference unchanged.
- R9: A read strobe at offset 0x0 (mode), 0x4 (reference), 0x8 (capture), 0xC (count) or 0x11 (event, bits [1:0]) loads that register into `rdata` at the next clock edge. Any other offset loads zero. `rdata` holds its value between reads, and writes to other offsets change nothing.
- R10: A write to offset 0xC presets the counter to the written value without restarting the prescaler. The counter then keeps counting from that value.
- R11: Any write to the mode or reference register resets the prescaler and the counter to zero.
- R12: While mode bit 3 (restart-on-reference) is 0, the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe; loads `rdata` at the next edge |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt for a reached reference |

## Verification
The assertions check the following on every cycle: the interrupt level against the enable bit and the reference flag; that the counter is frozen while the timer is disabled and no write occurs; that a reference match produces a zero count and a set flag; that ones written to the event register clear the flag; that a disabling mode write clears the reference; and that no tick is produced from an unsupported source. Only the bench scenarios can show tick spacing for each divider setting, the preset-then-count sequence, the retention of the reference on a write that does not disable the timer, and the read map with its one-cycle latency.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
  // register byte offsets
  localparam int OFF_MODE = 'h00;
  localparam int OFF_REF  = 'h04;
  localparam int OFF_CAP  = 'h08;
  localparam int OFF_CNT  = 'h0C;
  localparam int OFF_EVT  = 'h11;

  // mode field positions
  localparam int MB_EN      = 0;
  localparam int MB_SRC     = 1;
  localparam int MB_RESTART = 3;
  localparam int MB_IE      = 4;
  localparam int MB_PS      = 8;

  // event bits
  localparam int EV_CAP = 0;
  localparam int EV_REF = 1;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SYS16 = 2'd2,
    SRC_RSVD  = 2'd3
  } clk_src_e;
endpackage

// File: rtl/refcmp_prescaler.sv
module refcmp_prescaler #(
  parameter int PRESC_W = 8,
  parameter int SRC_DIV = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               div_sel,
  input  logic [PRESC_W-1:0] presc_max,
  input  logic               reload,
  output logic               tick
);
  localparam int PD_W = (SRC_DIV > 1) ? $clog2(SRC_DIV) : 1;
  localparam logic [PD_W-1:0] PD_LAST = PD_W'(SRC_DIV - 1);

  logic [PD_W-1:0]    prediv_q;
  logic [PRESC_W-1:0] presc_q;
  logic               base_tick;

  // the fixed divider produces one base tick per SRC_DIV clocks when selected
  assign base_tick = !div_sel || (prediv_q == PD_LAST);
  assign tick      = run && base_tick && (presc_q == presc_max);

  always_ff @(posedge clk) begin
    if (rst || reload || !run) begin
      prediv_q <= '0;
      presc_q  <= '0;
    end else begin
      if (div_sel) begin
        prediv_q <= (prediv_q == PD_LAST) ? '0 : prediv_q + 1'b1;
      end
      if (base_tick) begin
        presc_q <= (presc_q == presc_max) ? '0 : presc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic              preset,
  input  logic [DATA_W-1:0] preset_val,
  input  logic              tick,
  input  logic [DATA_W-1:0] ref_val,
  output logic [DATA_W-1:0] cnt_q,
  output logic              hit
);
  assign hit = tick && (cnt_q == ref_val);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q <= '0;
    end else if (preset) begin
      cnt_q <= preset_val;
    end else if (tick) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refcmp_regs.sv
module refcmp_regs
  import refcmp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               ref_hit,
  input  logic [DATA_W-1:0]  cnt_val,
  output logic [DATA_W-1:0]  mode_q,
  output logic [DATA_W-1:0]  ref_q,
  output logic [1:0]         evt_q,
  output logic               cnt_ld,
  output logic               reload,
  output logic               run,
  output logic               div_sel,
  output logic [PRESC_W-1:0] presc_max,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] mode_d, ref_d;
  logic [1:0]        evt_d, evt_clr;
  logic              wr_mode, wr_ref, wr_cap, wr_evt;
  clk_src_e          src;

  assign wr_mode = wr_en && (addr == ADDR_W'(OFF_MODE));
  assign wr_ref  = wr_en && (addr == ADDR_W'(OFF_REF));
  assign wr_cap  = wr_en && (addr == ADDR_W'(OFF_CAP));
  assign cnt_ld  = wr_en && (addr == ADDR_W'(OFF_CNT));
  assign wr_evt  = wr_en && (addr == ADDR_W'(OFF_EVT));
  assign reload  = wr_mode || wr_ref;

  assign src       = clk_src_e'(mode_q[MB_SRC +: 2]);
  assign run       = mode_q[MB_EN] && mode_q[MB_RESTART] &&
                     ((src == SRC_SYS) || (src == SRC_SYS16));
  assign div_sel   = (src == SRC_SYS16);
  assign presc_max = mode_q[MB_PS +: PRESC_W];

  always_comb begin
    mode_d = mode_q;
    ref_d  = ref_q;
    if (wr_mode) begin
      // a falling enable wipes the old settings before the new value lands
      if (mode_q[MB_EN] && !wdata[MB_EN]) ref_d = '0;
      mode_d = wdata;
    end
    if (wr_ref) ref_d = wdata;
    evt_clr = wr_evt ? wdata[1:0] : 2'b00;
    evt_d   = evt_q & ~evt_clr;
    if (ref_hit) evt_d[EV_REF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      evt_q  <= '0;
      irq    <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ref_q  <= ref_d;
      evt_q  <= evt_d;
      irq    <= mode_d[MB_IE] && evt_d[EV_REF];
      if (wr_cap) cap_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(OFF_MODE): rdata <= mode_q;
        ADDR_W'(OFF_REF):  rdata <= ref_q;
        ADDR_W'(OFF_CAP):  rdata <= cap_q;
        ADDR_W'(OFF_CNT):  rdata <= cnt_val;
        ADDR_W'(OFF_EVT):  rdata <= DATA_W'(evt_q);
        default:           rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int PRESC_W = 8,
  parameter int SRC_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0]  mode_q, ref_q, cnt_q;
  logic [1:0]         evt_q;
  logic               cnt_ld, reload, run, div_sel, tick, hit;
  logic [PRESC_W-1:0] presc_max;

  refcmp_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESC_W(PRESC_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ref_hit(hit), .cnt_val(cnt_q), .mode_q(mode_q),
    .ref_q(ref_q), .evt_q(evt_q), .cnt_ld(cnt_ld), .reload(reload),
    .run(run), .div_sel(div_sel), .presc_max(presc_max), .rdata(rdata),
    .irq(irq)
  );

  refcmp_prescaler #(
    .PRESC_W(PRESC_W), .SRC_DIV(SRC_DIV)
  ) u_presc (
    .clk(clk), .rst(rst), .run(run), .div_sel(div_sel),
    .presc_max(presc_max), .reload(reload), .tick(tick)
  );

  refcmp_counter #(
    .DATA_W(DATA_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .reload(reload), .preset(cnt_ld),
    .preset_val(wdata), .tick(tick), .ref_val(ref_q), .cnt_q(cnt_q),
    .hit(hit)
  );
endmodule

// File: rtl/refcmp_timer_checker.sv
module refcmp_timer_checker
  import refcmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] ref_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [1:0]        evt_q,
  input logic              tick
);
  logic ctl_wr;
  assign ctl_wr = wr_en && ((addr == ADDR_W'(OFF_MODE)) ||
                            (addr == ADDR_W'(OFF_REF)) ||
                            (addr == ADDR_W'(OFF_CNT)));

  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[MB_EN] && !wr_en) |=> $stable(cnt_q));

  p_bad_src_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode_q[MB_SRC +: 2] == 2'd0) || (mode_q[MB_SRC +: 2] == 2'd3)) |-> !tick);

  p_match_wraps_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctl_wr && (cnt_q == ref_q)) |=> ((cnt_q == '0) && evt_q[EV_REF]));

  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (mode_q[MB_IE] && evt_q[EV_REF]));

  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(OFF_EVT)) && wdata[EV_REF] &&
     !(tick && (cnt_q == ref_q))) |=> !evt_q[EV_REF]);

  p_disable_clears_ref_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(OFF_MODE)) && mode_q[MB_EN] && !wdata[MB_EN])
    |=> (ref_q == '0));

  p_ref_write_restarts_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(OFF_REF))) |=> (cnt_q == '0));
endmodule

bind refcmp_timer refcmp_timer_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .mode_q(mode_q), .ref_q(ref_q), .cnt_q(cnt_q),
  .evt_q(evt_q), .tick(tick)
);

// File: tb/refcmp_timer_bench.sv
`timescale 1ns/1ps
module refcmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  refcmp_timer u_refcmp_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 irq", {15'b0, irq}, 16'h0);
    rd(5'h00, v); check("R1 mode", v, 16'h0);
    rd(5'h04, v); check("R1 ref", v, 16'h0);
    rd(5'h08, v); check("R1 capture", v, 16'h0);
    rd(5'h0C, v); check("R1 count", v, 16'h0);
    rd(5'h11, v); check("R1 event", v, 16'h0);
  endtask

  task automatic t_dividers;
    logic [15:0] v;
    wr(5'h04, 16'hFFFF);
    wr(5'h00, 16'h010D);            // source 2, P=1: tick per 32 clocks
    idle(95);
    rd(5'h0C, v); check("R3 div16 P=1", v, 16'd2);
    wr(5'h00, 16'h030B);            // source 1, P=3: tick per 4 clocks
    idle(10);
    rd(5'h0C, v); check("R3 sys P=3", v, 16'd2);
  endtask

  task automatic t_restart;
    logic [15:0] v;
    wr(5'h00, 16'h000B);
    idle(20);
    rd(5'h0C, v); check("R11 running", v, 16'd20);
    wr(5'h04, 16'hFFFF);
    rd(5'h0C, v); check("R11 ref write zeroes count", v, 16'd0);
  endtask

  task automatic t_preset;
    logic [15:0] v;
    wr(5'h04, 16'd100);
    wr(5'h00, 16'h000B);
    idle(2);
    wr(5'h0C, 16'd50);
    idle(3);
    rd(5'h0C, v); check("R10 preset then count", v, 16'd53);
  endtask

  task automatic t_match_irq;
    logic [15:0] v;
    wr(5'h04, 16'd5);
    wr(5'h00, 16'h001B);            // enable, source 1, restart, irq enable
    idle(5);
    rd(5'h11, v); check("R5 flag before match", v, 16'h0);
    check("R6 irq after match", {15'b0, irq}, 16'h1);
    rd(5'h11, v); check("R5 flag after match", v, 16'h2);
    rd(5'h0C, v); check("R5 count restarted", v, 16'd1);
  endtask

  task automatic t_w1c;
    logic [15:0] v;
    wr(5'h00, 16'h0013);            // restart off: stopped, enable kept
    idle(10);
    rd(5'h0C, v); check("R12 no restart bit stops", v, 16'd0);
    check("R6 irq still high", {15'b0, irq}, 16'h1);
    wr(5'h11, 16'h0001);
    check("R7 write 0 to flag keeps it", {15'b0, irq}, 16'h1);
    rd(5'h11, v); check("R7 flag kept", v, 16'h2);
    wr(5'h11, 16'h0002);
    check("R6 irq low after clear", {15'b0, irq}, 16'h0);
    rd(5'h11, v); check("R7 flag cleared", v, 16'h0);
  endtask

  task automatic t_disable;
    logic [15:0] v;
    wr(5'h04, 16'h1234);
    wr(5'h00, 16'h0010);            // enable falls
    rd(5'h04, v); check("R8 ref cleared", v, 16'h0);
    rd(5'h00, v); check("R8 new mode stored", v, 16'h0010);
    wr(5'h04, 16'h0042);
    wr(5'h00, 16'h0000);            // enable already low
    rd(5'h04, v); check("R8 ref kept", v, 16'h0042);
    wr(5'h0C, 16'd7);
    idle(10);
    rd(5'h0C, v); check("R2 disabled holds", v, 16'd7);
  endtask

  task automatic t_bad_src_refzero;
    logic [15:0] v;
    wr(5'h04, 16'hFFFF);
    wr(5'h00, 16'h0009);            // source 0
    idle(20);
    rd(5'h0C, v); check("R4 source 0", v, 16'd0);
    wr(5'h00, 16'h000F);            // source 3
    idle(20);
    rd(5'h0C, v); check("R4 source 3", v, 16'd0);
    wr(5'h04, 16'h0000);
    wr(5'h00, 16'h000B);
    idle(10);
    rd(5'h0C, v); check("R5 ref zero count", v, 16'd0);
    rd(5'h11, v); check("R5 ref zero flag", v, 16'h2);
  endtask

  task automatic t_readmap;
    logic [15:0] v;
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'hBEEF);
    wr(5'h10, 16'hFFFF);            // unmapped offset
    rd(5'h08, v); check("R9 capture", v, 16'hBEEF);
    idle(3);
    check("R9 rdata holds", rdata, 16'hBEEF);
    rd(5'h10, v); check("R9 unmapped 0x10", v, 16'h0);
    rd(5'h1C, v); check("R9 unmapped 0x1C", v, 16'h0);
    rd(5'h00, v); check("R9 mode unaffected", v, 16'h0000);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dividers();
    t_restart();
    t_preset();
    t_match_irq();
    t_w1c();
    t_disable();
    t_bad_src_refzero();
    t_readmap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule